// File: doc/BRIEF.md
# UART Interrupt Source Identifier with Network Address Sources

This block sits next to a UART that can work on a multidrop serial network. It collects six interrupt conditions from the UART datapath. Each condition is latched in its own pending flag.

Two of the six conditions are specific to network use:
- address match: a received byte equals the station address;
- address sent: an address byte has left the transmitter.

The other four are the usual UART conditions: receive line error, receive data available, transmit holding empty and modem status change.

The block reports the most urgent enabled source as a four-bit identification value. The upper three bits carry a status code. Bit 0 is an active-low "no interrupt" flag. The block also drives a single interrupt line.

Each pending flag is cleared by the bus access that services it. The bus decoder turns register accesses into one-cycle strobes. The block also holds the 8-bit station address register.

Received bytes arrive on a valid-only stream (`rx_valid`, `rx_byte`). There is no ready signal and no back-pressure. Every byte presented with `rx_valid` high is compared against the station address in that same cycle. The upstream shifter never waits on this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `ident` is 4'b0001, `irq` is 0, no source is pending, and `addr_q` is 8'hAA.
- R2: `ident[0]` is 1 and `ident[3:1]` is 3'b000 exactly when no enabled source is pending. When any enabled source is pending, `ident[0]` is 0.
- R3: Status codes in `ident[3:1]` are:
  - receive line error: 3'b011
  - address match: 3'b110
  - receive data available: 3'b010
  - address sent: 3'b101
  - transmit holding empty: 3'b001
  - modem status: 3'b000
- R4: Among enabled pending sources, the one reported is the first in this order: line error, address match, receive data, address sent, transmit empty, modem status.
- R5: Enables gate reporting, not latching:
  - `en_line` gates line error;
  - `en_rx` gates both receive data and address match;
  - `en_tx` gates both address sent and transmit empty;
  - `en_modem` gates modem status.
  A disabled source stays pending and is reported once it is enabled.
- R6: A `rd_rxdata` strobe clears both the address-match and the receive-data flags.
- R7: A `rd_stat0` strobe clears the line-error flag. A `rd_stat1` strobe clears the modem-status flag.
- R8: A `wr_txdata` strobe clears both the address-sent and the transmit-empty flags. A `rd_ident` strobe clears only the one of those two that `ident` is reporting in that cycle, and leaves the other pending.
- R9: A flag whose event and clearing strobe occur in the same cycle stays set.
- R10: The address register loads `addr_wdata` on `addr_wr`, visible on `addr_q` the next cycle. A byte accepted on `rx_valid` that equals `addr_q` sets the address-match flag. A byte that differs leaves the flag unchanged.
- R11: `irq` is 1 in the cycle after any enabled source is pending, and 0 in the cycle after none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_line | input | 1 | Enable for the line-error source |
| en_rx | input | 1 | Enable for the receive-data and address-match sources |
| en_tx | input | 1 | Enable for the transmit-empty and address-sent sources |
| en_modem | input | 1 | Enable for the modem-status source |
| ev_line_err | input | 1 | Receive line error event |
| ev_rx_full | input | 1 | Receive data available event |
| ev_tx_empty | input | 1 | Transmit holding empty event |
| ev_modem | input | 1 | Modem status change event |
| ev_addr_sent | input | 1 | Address byte transmitted event |
| rx_valid | input | 1 | Received byte valid (always accepted) |
| rx_byte | input | 8 | Received byte |
| addr_wr | input | 1 | Station address write strobe |
| addr_wdata | input | 8 | Station address write data |
| addr_q | output | 8 | Station address register value |
| rd_rxdata | input | 1 | Receive data register read strobe |
| rd_stat0 | input | 1 | Line status register read strobe |
| rd_stat1 | input | 1 | Modem status register read strobe |
| rd_ident | input | 1 | Identification register read strobe |
| wr_txdata | input | 1 | Transmit data register write strobe |
| ident | output | 4 | {status code, active-low no-interrupt flag} |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench covers every combination of the six pending flags under all sixteen enable settings. This catches a swapped tie, such as receive data beating address match, or a disabled source that still leaks into `ident` or `irq`.

The bench checks that reading the identification register takes away only the transmit-side source being reported. A design that clears both would lose the transmit-empty report after an address-sent report.

The bench checks that an event arriving together with its own clearing strobe survives. A clear-first design would drop that event silently.

Address checks cover the reset value, a rewrite, a mismatch and a masked match that must surface once `en_rx` rises.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 6;
  localparam int CODE_W = 3;

  // Source slots, listed from highest to lowest priority
  localparam int S_LINE  = 0;
  localparam int S_AMAT  = 1;
  localparam int S_RXD   = 2;
  localparam int S_ASNT  = 3;
  localparam int S_TXE   = 4;
  localparam int S_MODEM = 5;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      S_LINE:  return 3'b011;
      S_AMAT:  return 3'b110;
      S_RXD:   return 3'b010;
      S_ASNT:  return 3'b101;
      S_TXE:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_o[g] <= 1'b0;
      else if (set_i[g])   pend_o[g] <= 1'b1;  // set has precedence
      else if (clr_i[g])   pend_o[g] <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_o[g]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !set_i[g]) |=> pend_o[g] == $past(pend_o[g]));
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      en_i,
  output logic [CODE_W-1:0] code_o,
  output logic              none_o
);
  logic [N-1:0] live;
  assign live = pend_i & en_i;

  // Walk from lowest to highest priority so the highest one lands last
  always_comb begin
    code_o = '0;
    none_o = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        code_o = src_code(i);
        none_o = 1'b0;
      end
    end
  end

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    none_o |-> (code_o == 3'b000 && live == '0));
  assert_line_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live[S_LINE] |-> (code_o == 3'b011 && !none_o));
  assert_amat_over_rxd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live[S_AMAT] && !live[S_LINE]) |-> code_o == 3'b110);
  assert_asnt_over_txe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live[S_ASNT] && live[S_TXE] && live[S_RXD:S_LINE] == '0) |-> code_o == 3'b101);
endmodule

// File: rtl/uart_irq_addr.sv
module uart_irq_addr #(
  parameter int          AW     = 8,
  parameter logic [AW-1:0] RST_VAL = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          rx_valid_i,
  input  logic [AW-1:0] rx_byte_i,
  output logic [AW-1:0] addr_o,
  output logic          hit_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_o <= RST_VAL;
    else if (wr_i) addr_o <= wdata_i;
  end

  assign hit_o = rx_valid_i && (rx_byte_i == addr_o);

  assert_addr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> addr_o == $past(wdata_i));
  assert_addr_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(addr_o));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int            AW       = 8,
  parameter logic [AW-1:0] ADDR_RST = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_line,
  input  logic          en_rx,
  input  logic          en_tx,
  input  logic          en_modem,
  input  logic          ev_line_err,
  input  logic          ev_rx_full,
  input  logic          ev_tx_empty,
  input  logic          ev_modem,
  input  logic          ev_addr_sent,
  input  logic          rx_valid,
  input  logic [AW-1:0] rx_byte,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  output logic [AW-1:0] addr_q,
  input  logic          rd_rxdata,
  input  logic          rd_stat0,
  input  logic          rd_stat1,
  input  logic          rd_ident,
  input  logic          wr_txdata,
  output logic [3:0]    ident,
  output logic          irq
);
  logic [NSRC-1:0]   set_v, clr_v, pend, en_v;
  logic [CODE_W-1:0] code;
  logic              none, hit, irq_q;

  uart_irq_addr #(.AW(AW), .RST_VAL(ADDR_RST)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_i(addr_wr), .wdata_i(addr_wdata),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .addr_o(addr_q), .hit_o(hit)
  );

  always_comb begin
    set_v          = '0;
    set_v[S_LINE]  = ev_line_err;
    set_v[S_AMAT]  = hit;
    set_v[S_RXD]   = ev_rx_full;
    set_v[S_ASNT]  = ev_addr_sent;
    set_v[S_TXE]   = ev_tx_empty;
    set_v[S_MODEM] = ev_modem;

    en_v          = '0;
    en_v[S_LINE]  = en_line;
    en_v[S_AMAT]  = en_rx;
    en_v[S_RXD]   = en_rx;
    en_v[S_ASNT]  = en_tx;
    en_v[S_TXE]   = en_tx;
    en_v[S_MODEM] = en_modem;

    // A read of the identification register retires only the transmit-side
    // source it reports in that same cycle
    clr_v          = '0;
    clr_v[S_LINE]  = rd_stat0;
    clr_v[S_AMAT]  = rd_rxdata;
    clr_v[S_RXD]   = rd_rxdata;
    clr_v[S_ASNT]  = wr_txdata | (rd_ident && !none && code == src_code(S_ASNT));
    clr_v[S_TXE]   = wr_txdata | (rd_ident && !none && code == src_code(S_TXE));
    clr_v[S_MODEM] = rd_stat1;
  end

  uart_irq_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
  );

  uart_irq_prio #(.N(NSRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en_v),
    .code_o(code), .none_o(none)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= !none;
  end

  assign ident = {code, none};
  assign irq   = irq_q;

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(ident[0] == 1'b0) || $past(!rst_n));
  assert_ident_read_keeps_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && !none && code == 3'b001 && !wr_txdata && !ev_addr_sent)
      |=> pend[S_ASNT] == $past(pend[S_ASNT]));
  assert_mismatch_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_byte != addr_q && !rd_rxdata) |=> pend[S_AMAT] == $past(pend[S_AMAT]));
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_line, en_rx, en_tx, en_modem;
  logic ev_line_err, ev_rx_full, ev_tx_empty, ev_modem, ev_addr_sent;
  logic rx_valid, addr_wr, rd_rxdata, rd_stat0, rd_stat1, rd_ident, wr_txdata;
  logic [7:0] rx_byte, addr_wdata, addr_q;
  logic [3:0] ident;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .en_line(en_line), .en_rx(en_rx), .en_tx(en_tx),
    .en_modem(en_modem), .ev_line_err(ev_line_err), .ev_rx_full(ev_rx_full),
    .ev_tx_empty(ev_tx_empty), .ev_modem(ev_modem), .ev_addr_sent(ev_addr_sent),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .addr_wr(addr_wr),
    .addr_wdata(addr_wdata), .addr_q(addr_q), .rd_rxdata(rd_rxdata),
    .rd_stat0(rd_stat0), .rd_stat1(rd_stat1), .rd_ident(rd_ident),
    .wr_txdata(wr_txdata), .ident(ident), .irq(irq)
  );

  // p bits: 0 line, 1 addr match, 2 rx data, 3 addr sent, 4 tx empty, 5 modem
  // e bits: 0 line, 1 rx, 2 tx, 3 modem
  function automatic logic [3:0] model(input logic [5:0] p, input logic [3:0] e);
    logic [5:0] live;
    live = p & {e[3], e[2], e[2], e[1], e[1], e[0]};
    if (live[0]) return 4'b0110;
    if (live[1]) return 4'b1100;
    if (live[2]) return 4'b0100;
    if (live[3]) return 4'b1010;
    if (live[4]) return 4'b0010;
    if (live[5]) return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    {ev_line_err, ev_rx_full, ev_tx_empty, ev_modem, ev_addr_sent} = '0;
    {rx_valid, addr_wr, rd_rxdata, rd_stat0, rd_stat1, rd_ident, wr_txdata} = '0;
    rx_byte = 8'h00; addr_wdata = 8'h00;
  endtask

  task automatic clear_all();
    rd_rxdata = 1; rd_stat0 = 1; rd_stat1 = 1; wr_txdata = 1;
    step(); idle();
  endtask

  task automatic raise(input logic [5:0] p);
    ev_line_err = p[0]; rx_valid = p[1]; rx_byte = 8'hAA; ev_rx_full = p[2];
    ev_addr_sent = p[3]; ev_tx_empty = p[4]; ev_modem = p[5];
    step(); idle();
  endtask

  initial begin
    idle();
    {en_line, en_rx, en_tx, en_modem} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ident", {4'h0, ident}, 8'h01);
    check("R1 irq", {7'h0, irq}, 8'h00);
    check("R1 addr", addr_q, 8'hAA);

    // R2 R3 R4 R5 R11: every pending pattern under every enable pattern
    for (int p = 0; p < 64; p++) begin
      for (int e = 0; e < 16; e++) begin
        {en_modem, en_tx, en_rx, en_line} = e[3:0];
        raise(p[5:0]);
        check("R4 ident sweep", {4'h0, ident}, {4'h0, model(p[5:0], e[3:0])});
        step();
        check("R11 irq sweep", {7'h0, irq}, {7'h0, model(p[5:0], e[3:0]) != 4'b0001});
        clear_all();
        check("R2 cleared", {4'h0, ident}, 8'h01);
      end
    end

    {en_line, en_rx, en_tx, en_modem} = 4'hF;
    // R6: receive read clears both receive-side flags
    raise(6'b000110);
    rd_rxdata = 1; step(); idle();
    check("R6 rx read clears", {4'h0, ident}, 8'h01);
    // R7
    raise(6'b100001);
    rd_stat0 = 1; step(); idle();
    check("R7 stat0 clears line", {4'h0, ident}, 8'h00);
    rd_stat1 = 1; step(); idle();
    check("R7 stat1 clears modem", {4'h0, ident}, 8'h01);
    // R8: ident read retires only the reported transmit source
    raise(6'b011000);
    check("R8 addr sent first", {4'h0, ident}, 8'h0A);
    rd_ident = 1; step(); idle();
    check("R8 tx empty remains", {4'h0, ident}, 8'h02);
    rd_ident = 1; step(); idle();
    check("R8 second ident read", {4'h0, ident}, 8'h01);
    raise(6'b011000);
    wr_txdata = 1; step(); idle();
    check("R8 tx write clears both", {4'h0, ident}, 8'h01);
    // R9: event and clear in the same cycle
    ev_line_err = 1; rd_stat0 = 1; step(); idle();
    check("R9 set wins", {4'h0, ident}, 8'h06);
    rd_stat0 = 1; step(); idle();
    check("R9 later clear", {4'h0, ident}, 8'h01);
    // R10: address register and compare
    addr_wr = 1; addr_wdata = 8'h3C; step(); idle();
    check("R10 addr write", addr_q, 8'h3C);
    rx_valid = 1; rx_byte = 8'hAA; step(); idle();
    check("R10 mismatch", {4'h0, ident}, 8'h01);
    rx_valid = 1; rx_byte = 8'h3C; step(); idle();
    check("R10 match", {4'h0, ident}, 8'h0C);
    rd_rxdata = 1; step(); idle();
    // R5: masked match stays pending
    en_rx = 0;
    rx_valid = 1; rx_byte = 8'h3C; step(); idle();
    check("R5 masked ident", {4'h0, ident}, 8'h01);
    step();
    check("R5 masked irq", {7'h0, irq}, 8'h00);
    en_rx = 1; @(negedge clk);
    check("R5 unmasked ident", {4'h0, ident}, 8'h0C);
    step();
    check("R11 irq rises", {7'h0, irq}, 8'h01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule